// File: doc/BRIEF.md
# Per-Pin GPIO Source Selector

This block decides, pin by pin, which agent drives two banks of general-purpose I/O pins. Seven agents can own a pin: processor software, management software, user application logic, either of the two radio channels of daughterboard 0 or 1, and the SPI controller of daughterboard 0 or 1. Each pin carries one bit in each of several configuration bit-planes. A layered decision over those bits picks the owner. The owner's data and output-enable then become the pin's registered outputs.

The configuration sits in word registers on a simple 32-bit read/write bus. Every register word uses the same bank layout: the pins of bank 0 sit in the low half-word and the pins of bank 1 sit in the high half-word, and the reserved bits between them are unused. Management software drives its pins from an output-value register and a direction register held in the block. The pad levels come back through a two-stage synchroniser into a read-only input register.

Top module: `gpio_src_sel`

## Requirements
- R1: After reset every register reads zero and every pin is owned by user application logic.
- R2: Pin p of bank b lives at bit b*16+p of every register word (bank 0 in bits 11:0, bank 1 in bits 27:16). Bits 15:12 and 31:28 read as zero and ignore writes.
- R3: Word offsets from BASE_ADDR are decoded as follows: 0x00 master, 0x04 direction, 0x08 input, 0x0C output value, 0x10 source, 0x14 radio-board select, 0x18 SPI-board select, 0x1C override, 0x20 software-select and 0x24 channel. Unaligned, unmapped or below-base addresses read zero, and writes to them change nothing.
- R4: A pin with source=1 and override=1 takes data and enable from the SPI controller of the daughterboard named by its SPI-board select bit.
- R5: A pin with source=1 and override=0 takes data and enable from the radio of the daughterboard named by its radio-board select bit, on the channel named by its channel bit.
- R6: A pin with source=0, master=1 and software-select=1 takes data and enable from the processor software port.
- R7: A pin with source=0, master=1 and software-select=0 is driven by management software. Its data is the pin's output-value register bit and its enable is the pin's direction bit (1 = output).
- R8: A pin with source=0 and master=0 takes data and enable from user application logic.
- R9: The input register shows the pad levels two clock edges after they are sampled, and writes to it are ignored.
- R10: The pin outputs are registered and reflect configuration or agent changes at the first clock edge after the change.
- R11: A read request returns its data on bus_rdata at the first clock edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| usr_out | input | NUM_BANKS*NUM_PINS | User logic pin data |
| usr_oe | input | NUM_BANKS*NUM_PINS | User logic output enables |
| proc_out | input | NUM_BANKS*NUM_PINS | Processor software pin data |
| proc_oe | input | NUM_BANKS*NUM_PINS | Processor software output enables |
| radio_out | input | 4*NUM_BANKS*NUM_PINS | Radio data, slice (board*2+channel) |
| radio_oe | input | 4*NUM_BANKS*NUM_PINS | Radio output enables, same slicing |
| spi_out | input | 2*NUM_BANKS*NUM_PINS | SPI data, slice per board |
| spi_oe | input | 2*NUM_BANKS*NUM_PINS | SPI output enables, slice per board |
| pad_in | input | NUM_BANKS*NUM_PINS | Asynchronous pad levels |
| pin_out | output | NUM_BANKS*NUM_PINS | Registered pin data |
| pin_oe | output | NUM_BANKS*NUM_PINS | Registered pin output enables |

## Verification
The hardest situation to reach is complete coverage of the decision tree on every pin. Each pin's owner depends on seven bits spread over seven separate register words, and those words are shared by all 24 pins. The stimulus staggers the configuration: in round k, pin i takes the 7-bit pattern (k+5i) mod 128. Over 128 rounds, every pin therefore passes through every combination while the pins are always configured differently from each other. Each agent gets its own hashed data in every round, so a wrong owner, board or channel cannot produce the right value by chance.

// File: rtl/gpio_src_pkg.sv
package gpio_src_pkg;

  // Who owns a pin
  typedef enum logic [2:0] {
    AG_USER  = 3'd0,
    AG_MGMT  = 3'd1,
    AG_PROC  = 3'd2,
    AG_RADIO = 3'd3,
    AG_SPI   = 3'd4
  } agent_e;

  typedef struct packed {
    agent_e agent;
    logic   board;   // daughterboard index for radio/SPI
    logic   chan;    // radio channel
  } pin_sel_t;

  // Word indices (byte offset / 4)
  localparam int unsigned W_MASTER = 0;
  localparam int unsigned W_DIR    = 1;
  localparam int unsigned W_INPUT  = 2;
  localparam int unsigned W_OUTVAL = 3;
  localparam int unsigned W_SRC    = 4;
  localparam int unsigned W_RBOARD = 5;
  localparam int unsigned W_SBOARD = 6;
  localparam int unsigned W_OVR    = 7;
  localparam int unsigned W_SWSEL  = 8;
  localparam int unsigned W_CHAN   = 9;
  localparam int unsigned NUM_WORDS = 10;

  localparam int unsigned NUM_BOARDS = 2;
  localparam int unsigned NUM_CHANS  = 2;

endpackage

// File: rtl/gpio_src_sync.sv
module gpio_src_sync #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_src_regs.sv
module gpio_src_regs
  import gpio_src_pkg::*;
#(
  parameter int unsigned        NUM_BANKS   = 2,
  parameter int unsigned        NUM_PINS    = 12,
  parameter int unsigned        BANK_STRIDE = 16,
  parameter int unsigned        ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_BANKS*NUM_PINS-1:0] pad_sync,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_master,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_dir,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_outval,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_src,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_rboard,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_sboard,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_ovr,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_swsel,
  output logic [NUM_BANKS*NUM_PINS-1:0] pl_chan
);
  localparam int unsigned TOTAL = NUM_BANKS * NUM_PINS;
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * 4);

  logic [TOTAL-1:0]  cfg_q [NUM_WORDS];
  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic [IDX_W-1:0]  widx;
  logic [TOTAL-1:0]  wr_bits;
  logic [TOTAL-1:0]  rd_bits;
  logic [31:0]       rd_word;

  assign offset = addr - BASE_ADDR;
  assign hit    = (addr >= BASE_ADDR) && (offset < SPAN) && (offset[1:0] == 2'b00);
  assign widx   = offset[IDX_W+1:2];

  // Word layout -> flat pin vector
  always_comb begin
    wr_bits = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        wr_bits[b*NUM_PINS+p] = wdata[b*BANK_STRIDE+p];
      end
    end
  end

  // Flat pin vector -> word layout, reserved bits zero
  always_comb begin
    rd_bits = (widx == IDX_W'(W_INPUT)) ? pad_sync : cfg_q[widx];
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        rd_word[b*BANK_STRIDE+p] = rd_bits[b*NUM_PINS+p];
      end
    end
  end

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      if (w == W_INPUT) begin : g_ro
        always_ff @(posedge clk) cfg_q[w] <= '0;
      end else begin : g_rw
        always_ff @(posedge clk) begin
          if (rst) begin
            cfg_q[w] <= '0;
          end else if (wr_en && hit && (widx == IDX_W'(w))) begin
            cfg_q[w] <= wr_bits;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= hit ? rd_word : 32'h0;
    end
  end

  assign pl_master = cfg_q[W_MASTER];
  assign pl_dir    = cfg_q[W_DIR];
  assign pl_outval = cfg_q[W_OUTVAL];
  assign pl_src    = cfg_q[W_SRC];
  assign pl_rboard = cfg_q[W_RBOARD];
  assign pl_sboard = cfg_q[W_SBOARD];
  assign pl_ovr    = cfg_q[W_OVR];
  assign pl_swsel  = cfg_q[W_SWSEL];
  assign pl_chan   = cfg_q[W_CHAN];
endmodule

// File: rtl/gpio_src_decide.sv
module gpio_src_decide
  import gpio_src_pkg::*;
#(
  parameter int unsigned TOTAL = 24
) (
  input  logic [TOTAL-1:0]     pl_src,
  input  logic [TOTAL-1:0]     pl_ovr,
  input  logic [TOTAL-1:0]     pl_sboard,
  input  logic [TOTAL-1:0]     pl_rboard,
  input  logic [TOTAL-1:0]     pl_chan,
  input  logic [TOTAL-1:0]     pl_master,
  input  logic [TOTAL-1:0]     pl_swsel,
  output pin_sel_t [TOTAL-1:0] sel
);
  // Layered priority: source plane first, then override or master, then the leaf bit
  always_comb begin
    for (int i = 0; i < TOTAL; i++) begin
      sel[i].board = 1'b0;
      sel[i].chan  = 1'b0;
      if (pl_src[i]) begin
        if (pl_ovr[i]) begin
          sel[i].agent = AG_SPI;
          sel[i].board = pl_sboard[i];
        end else begin
          sel[i].agent = AG_RADIO;
          sel[i].board = pl_rboard[i];
          sel[i].chan  = pl_chan[i];
        end
      end else if (pl_master[i]) begin
        sel[i].agent = pl_swsel[i] ? AG_PROC : AG_MGMT;
      end else begin
        sel[i].agent = AG_USER;
      end
    end
  end
endmodule

// File: rtl/gpio_src_mux.sv
module gpio_src_mux
  import gpio_src_pkg::*;
#(
  parameter int unsigned TOTAL = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pin_sel_t [TOTAL-1:0] sel,
  input  logic [TOTAL-1:0]     pl_outval,
  input  logic [TOTAL-1:0]     pl_dir,
  input  logic [TOTAL-1:0]     usr_out,
  input  logic [TOTAL-1:0]     usr_oe,
  input  logic [TOTAL-1:0]     proc_out,
  input  logic [TOTAL-1:0]     proc_oe,
  input  logic [NUM_BOARDS*NUM_CHANS*TOTAL-1:0] radio_out,
  input  logic [NUM_BOARDS*NUM_CHANS*TOTAL-1:0] radio_oe,
  input  logic [NUM_BOARDS*TOTAL-1:0]           spi_out,
  input  logic [NUM_BOARDS*TOTAL-1:0]           spi_oe,
  output logic [TOTAL-1:0]     pin_out,
  output logic [TOTAL-1:0]     pin_oe
);
  logic [TOTAL-1:0] nxt_out;
  logic [TOTAL-1:0] nxt_oe;

  always_comb begin
    for (int i = 0; i < TOTAL; i++) begin
      case (sel[i].agent)
        AG_SPI: begin
          nxt_out[i] = spi_out[int'(sel[i].board)*TOTAL + i];
          nxt_oe[i]  = spi_oe[int'(sel[i].board)*TOTAL + i];
        end
        AG_RADIO: begin
          nxt_out[i] = radio_out[int'({sel[i].board, sel[i].chan})*TOTAL + i];
          nxt_oe[i]  = radio_oe[int'({sel[i].board, sel[i].chan})*TOTAL + i];
        end
        AG_PROC: begin
          nxt_out[i] = proc_out[i];
          nxt_oe[i]  = proc_oe[i];
        end
        AG_MGMT: begin
          nxt_out[i] = pl_outval[i];
          nxt_oe[i]  = pl_dir[i];
        end
        default: begin
          nxt_out[i] = usr_out[i];
          nxt_oe[i]  = usr_oe[i];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
    end
  end
endmodule

// File: rtl/gpio_src_sel.sv
module gpio_src_sel
  import gpio_src_pkg::*;
#(
  parameter int unsigned       NUM_BANKS   = 2,
  parameter int unsigned       NUM_PINS    = 12,
  parameter int unsigned       BANK_STRIDE = 16,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0400
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         bus_wr_en,
  input  logic                                         bus_rd_en,
  input  logic [ADDR_W-1:0]                            bus_addr,
  input  logic [31:0]                                  bus_wdata,
  output logic [31:0]                                  bus_rdata,
  input  logic [NUM_BANKS*NUM_PINS-1:0]                usr_out,
  input  logic [NUM_BANKS*NUM_PINS-1:0]                usr_oe,
  input  logic [NUM_BANKS*NUM_PINS-1:0]                proc_out,
  input  logic [NUM_BANKS*NUM_PINS-1:0]                proc_oe,
  input  logic [NUM_BOARDS*NUM_CHANS*NUM_BANKS*NUM_PINS-1:0] radio_out,
  input  logic [NUM_BOARDS*NUM_CHANS*NUM_BANKS*NUM_PINS-1:0] radio_oe,
  input  logic [NUM_BOARDS*NUM_BANKS*NUM_PINS-1:0]     spi_out,
  input  logic [NUM_BOARDS*NUM_BANKS*NUM_PINS-1:0]     spi_oe,
  input  logic [NUM_BANKS*NUM_PINS-1:0]                pad_in,
  output logic [NUM_BANKS*NUM_PINS-1:0]                pin_out,
  output logic [NUM_BANKS*NUM_PINS-1:0]                pin_oe
);
  localparam int unsigned TOTAL = NUM_BANKS * NUM_PINS;

  logic [TOTAL-1:0] pad_sync;
  logic [TOTAL-1:0] pl_master, pl_dir, pl_outval, pl_src, pl_rboard;
  logic [TOTAL-1:0] pl_sboard, pl_ovr, pl_swsel, pl_chan;
  pin_sel_t [TOTAL-1:0] sel;

  gpio_src_sync #(.WIDTH(TOTAL)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_src_regs #(
    .NUM_BANKS   (NUM_BANKS),
    .NUM_PINS    (NUM_PINS),
    .BANK_STRIDE (BANK_STRIDE),
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .pad_sync  (pad_sync),
    .pl_master (pl_master),
    .pl_dir    (pl_dir),
    .pl_outval (pl_outval),
    .pl_src    (pl_src),
    .pl_rboard (pl_rboard),
    .pl_sboard (pl_sboard),
    .pl_ovr    (pl_ovr),
    .pl_swsel  (pl_swsel),
    .pl_chan   (pl_chan)
  );

  gpio_src_decide #(.TOTAL(TOTAL)) u_decide (
    .pl_src    (pl_src),
    .pl_ovr    (pl_ovr),
    .pl_sboard (pl_sboard),
    .pl_rboard (pl_rboard),
    .pl_chan   (pl_chan),
    .pl_master (pl_master),
    .pl_swsel  (pl_swsel),
    .sel       (sel)
  );

  gpio_src_mux #(.TOTAL(TOTAL)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .pl_outval (pl_outval),
    .pl_dir    (pl_dir),
    .usr_out   (usr_out),
    .usr_oe    (usr_oe),
    .proc_out  (proc_out),
    .proc_oe   (proc_oe),
    .radio_out (radio_out),
    .radio_oe  (radio_oe),
    .spi_out   (spi_out),
    .spi_oe    (spi_oe),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );
endmodule

// File: rtl/gpio_src_sel_chk.sv
module gpio_src_sel_chk #(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned BANK_STRIDE = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic [31:0]                      bus_rdata,
  input logic [NUM_BANKS*NUM_PINS-1:0]    usr_out,
  input logic [NUM_BANKS*NUM_PINS-1:0]    usr_oe,
  input logic [NUM_BANKS*NUM_PINS-1:0]    proc_out,
  input logic [NUM_BANKS*NUM_PINS-1:0]    proc_oe,
  input logic [4*NUM_BANKS*NUM_PINS-1:0]  radio_out,
  input logic [4*NUM_BANKS*NUM_PINS-1:0]  radio_oe,
  input logic [2*NUM_BANKS*NUM_PINS-1:0]  spi_out,
  input logic [2*NUM_BANKS*NUM_PINS-1:0]  spi_oe,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pad_in,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pad_sync,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_master,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_dir,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_outval,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_src,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_rboard,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_sboard,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_ovr,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_swsel,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pl_chan,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pin_out,
  input logic [NUM_BANKS*NUM_PINS-1:0]    pin_oe
);
  localparam int unsigned TOTAL = NUM_BANKS * NUM_PINS;

  function automatic logic [31:0] used_mask();
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int p = 0; p < NUM_PINS; p++)
        m[b*BANK_STRIDE+p] = 1'b1;
    return m;
  endfunction
  localparam logic [31:0] RSV_MASK = ~used_mask();

  logic [TOTAL-1:0] spi_d, spi_e, rad_d, rad_e;
  always_comb begin
    for (int i = 0; i < TOTAL; i++) begin
      spi_d[i] = spi_out[int'(pl_sboard[i])*TOTAL + i];
      spi_e[i] = spi_oe[int'(pl_sboard[i])*TOTAL + i];
      rad_d[i] = radio_out[int'({pl_rboard[i], pl_chan[i]})*TOTAL + i];
      rad_e[i] = radio_oe[int'({pl_rboard[i], pl_chan[i]})*TOTAL + i];
    end
  end

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & RSV_MASK) == 32'h0); // R2

  AST_INPUT_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> pad_sync == $past(pad_in, 2)); // R9

  generate
    for (genvar i = 0; i < TOTAL; i++) begin : g_pin
      AST_SPI_OWNER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pl_src[i] && pl_ovr[i]))
        |-> (pin_out[i] == $past(spi_d[i]) && pin_oe[i] == $past(spi_e[i]))); // R4
      AST_RADIO_OWNER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pl_src[i] && !pl_ovr[i]))
        |-> (pin_out[i] == $past(rad_d[i]) && pin_oe[i] == $past(rad_e[i]))); // R5
      AST_PROC_OWNER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!pl_src[i] && pl_master[i] && pl_swsel[i]))
        |-> (pin_out[i] == $past(proc_out[i]) && pin_oe[i] == $past(proc_oe[i]))); // R6
      AST_MGMT_OWNER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!pl_src[i] && pl_master[i] && !pl_swsel[i]))
        |-> (pin_out[i] == $past(pl_outval[i]) && pin_oe[i] == $past(pl_dir[i]))); // R7
      AST_USER_OWNER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!pl_src[i] && !pl_master[i]))
        |-> (pin_out[i] == $past(usr_out[i]) && pin_oe[i] == $past(usr_oe[i]))); // R8
    end
  endgenerate
endmodule

bind gpio_src_sel gpio_src_sel_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .NUM_PINS    (NUM_PINS),
  .BANK_STRIDE (BANK_STRIDE)
) u_chk (.*);

// File: tb/tb_gpio_src_sel.sv
module tb_gpio_src_sel;
  localparam int T = 24;
  localparam logic [15:0] BASE = 16'h0400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [T-1:0] usr_out = '0, usr_oe = '0, proc_out = '0, proc_oe = '0, pad_in = '0;
  logic [4*T-1:0] radio_out = '0, radio_oe = '0;
  logic [2*T-1:0] spi_out = '0, spi_oe = '0;
  logic [T-1:0] pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_src_sel #(.BASE_ADDR(BASE)) dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [T-1:0] v);
    return {4'h0, v[23:12], 4'h0, v[11:0]};
  endfunction

  function automatic logic [23:0] mix(input int k, input int s);
    logic [31:0] v;
    v = k * 32'h9E3779B1 + s * 32'h7F4A7C15;
    v = v ^ (v >> 15);
    v = v * 32'h2C1B3C6D;
    v = v ^ (v >> 12);
    return v[23:0];
  endfunction

  // All tasks start and end just after a falling edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  logic [T-1:0] b_master, b_dir, b_outval, b_src, b_rb, b_sb, b_ovr, b_sw, b_ch;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values of all words
    for (int w = 0; w < 10; w++) begin
      rd(BASE + 16'(w*4), r);
      chk("R1", $sformatf("reset word %0d", w), r, 32'h0);
    end
    usr_out = 24'hA5C3F0; usr_oe = 24'h0F0F0F;
    @(negedge clk);
    chk("R1", "reset owner data", pin_out, 24'hA5C3F0);
    chk("R1", "reset owner enable", pin_oe, 24'h0F0F0F);

    // R11: read data one edge after request
    wr(BASE + 16'h0C, 32'h0ABC0123);
    rd(BASE + 16'h0C, r);
    chk("R11", "read latency", r, 32'h0ABC0123);

    // R2: reserved bits
    wr(BASE + 16'h10, 32'hFFFFFFFF);
    rd(BASE + 16'h10, r);
    chk("R2", "reserved masked", r, 32'h0FFF0FFF);
    wr(BASE + 16'h00, 32'hF000F000);
    rd(BASE + 16'h00, r);
    chk("R2", "reserved only write", r, 32'h0);
    wr(BASE + 16'h10, 32'h0);

    // R3: each RW word holds its own value
    for (int w = 0; w < 10; w++)
      if (w != 2) wr(BASE + 16'(w*4), pack(mix(w, 99)));
    for (int w = 0; w < 10; w++) begin
      if (w != 2) begin
        rd(BASE + 16'(w*4), r);
        chk("R3", $sformatf("word %0d readback", w), r, pack(mix(w, 99)));
      end
    end
    wr(BASE + 16'h28, 32'hFFFFFFFF);
    wr(BASE + 16'h01, 32'hFFFFFFFF);
    wr(BASE - 16'h04, 32'hFFFFFFFF);
    rd(BASE + 16'h28, r); chk("R3", "unmapped read", r, 32'h0);
    rd(BASE + 16'h05, r); chk("R3", "unaligned read", r, 32'h0);
    rd(BASE - 16'h04, r); chk("R3", "below-base read", r, 32'h0);
    rd(BASE + 16'h00, r); chk("R3", "master unchanged", r, pack(mix(0, 99)));
    rd(BASE + 16'h04, r); chk("R3", "direction unchanged", r, pack(mix(1, 99)));
    for (int w = 0; w < 10; w++)
      if (w != 2) wr(BASE + 16'(w*4), 32'h0);

    // R9: input capture through two stages, writes ignored
    pad_in = 24'h5A3C96;
    rd(BASE + 16'h08, r);
    chk("R9", "input not yet visible", r, 32'h0);
    @(negedge clk);
    rd(BASE + 16'h08, r);
    chk("R9", "input after two edges", r, pack(24'h5A3C96));
    wr(BASE + 16'h08, 32'h0);
    rd(BASE + 16'h08, r);
    chk("R9", "input write ignored", r, pack(24'h5A3C96));

    // R10: one-edge output latency
    usr_out = 24'h123456;
    chk("R10", "before edge", pin_out, 24'hA5C3F0);
    @(negedge clk);
    chk("R10", "after edge", pin_out, 24'h123456);

    // R4..R8: staggered exhaustive sweep of the decision bits
    for (int k = 0; k < 128; k++) begin
      for (int i = 0; i < T; i++) begin
        int c;
        c = (k + 5*i) % 128;
        b_src[i] = c[0]; b_ovr[i] = c[1]; b_sb[i] = c[2]; b_rb[i] = c[3];
        b_ch[i] = c[4]; b_master[i] = c[5]; b_sw[i] = c[6];
      end
      b_outval = mix(k, 20);
      b_dir    = mix(k, 21);
      wr(BASE + 16'h00, pack(b_master));
      wr(BASE + 16'h04, pack(b_dir));
      wr(BASE + 16'h0C, pack(b_outval));
      wr(BASE + 16'h10, pack(b_src));
      wr(BASE + 16'h14, pack(b_rb));
      wr(BASE + 16'h18, pack(b_sb));
      wr(BASE + 16'h1C, pack(b_ovr));
      wr(BASE + 16'h20, pack(b_sw));
      wr(BASE + 16'h24, pack(b_ch));
      usr_out = mix(k, 1); usr_oe = mix(k, 2);
      proc_out = mix(k, 3); proc_oe = mix(k, 4);
      for (int j = 0; j < 4; j++) begin
        radio_out[j*T +: T] = mix(k, 5 + j);
        radio_oe[j*T +: T]  = mix(k, 9 + j);
      end
      for (int j = 0; j < 2; j++) begin
        spi_out[j*T +: T] = mix(k, 13 + j);
        spi_oe[j*T +: T]  = mix(k, 15 + j);
      end
      @(negedge clk);
      for (int i = 0; i < T; i++) begin
        logic ed, eo;
        string tag;
        int j;
        if (b_src[i] && b_ovr[i]) begin
          j = b_sb[i]; ed = spi_out[j*T+i]; eo = spi_oe[j*T+i]; tag = "R4";
        end else if (b_src[i]) begin
          j = 2*b_rb[i] + b_ch[i]; ed = radio_out[j*T+i]; eo = radio_oe[j*T+i]; tag = "R5";
        end else if (b_master[i] && b_sw[i]) begin
          ed = proc_out[i]; eo = proc_oe[i]; tag = "R6";
        end else if (b_master[i]) begin
          ed = b_outval[i]; eo = b_dir[i]; tag = "R7";
        end else begin
          ed = usr_out[i]; eo = usr_oe[i]; tag = "R8";
        end
        chk(tag, $sformatf("round %0d pin %0d data", k, i), 32'(pin_out[i]), 32'(ed));
        chk(tag, $sformatf("round %0d pin %0d enable", k, i), 32'(pin_oe[i]), 32'(eo));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule